// File: doc/BRIEF.md
# Partitioned SIMD Equality Comparator

This block compares two 32-bit operands for equality while treating the word as a set of lanes. A 3-bit cut-enable vector selects where the lanes begin and end. Each enable bit opens one boundary at a fixed bit position. Neighbouring segments with no open boundary between them form one wider lane. The block returns one equality flag per lane.

Each lane's flag is placed on the result bit whose index is the lowest segment in that lane. Result bits that do not start a lane read 0. The block is purely combinational. It has no clock, no reset and no handshake, so a caller can use it as one stage inside a packed-data compare or branch path and register the result wherever its own timing needs it.

Top module: `part_eq`

## Requirements
- R1: The word is split into four segments. Segment 0 is bits [3:0], segment 1 is bits [7:4], segment 2 is bits [11:8] and segment 3 is bits [31:12]. A difference in any bit affects only the lane that holds that bit's segment.
- R2: Enable bit `cut_en[i]` (i = 0..2) sits between segment i and segment i+1. When it is 1, the two segments fall in different lanes. When it is 0, they belong to the same lane.
- R3: A lane's flag is 1 exactly when every segment inside that lane has equal operand bits.
- R4: A lane's flag drives `lane_eq[k]`, where k is the lowest segment index in the lane. Segment 0 always starts a lane. Segment k (k > 0) starts a lane exactly when `cut_en[k-1]` is 1. With equal operands, `lane_eq` therefore equals `{cut_en, 1'b1}`.
- R5: Every bit of `lane_eq` that does not start a lane is 0 for any operands.
- R6: With `cut_en = 3'b000`, `lane_eq[0]` is the full 32-bit equality and `lane_eq[3:1]` is 0.
- R7: With `cut_en = 3'b111`, `lane_eq[i]` is the equality of segment i alone, for each i.
- R8: The result is combinational. It follows any change on `opa`, `opb` or `cut_en` with no clock.
- R9: When the operands differ in exactly one bit, only the flag of the lane holding that bit is 0. Every other lane-start flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| cut_en | input | 3 | Boundary enables; bit i opens the cut between segment i and i+1 |
| lane_eq | output | 4 | Per-lane equality flag, at the lowest segment index of each lane |

## Verification
Two functions meet in one evaluation: merging segments into a lane, and reporting a mismatch confined to one segment. Both happen whenever a single differing bit lands in a merged lane while a neighbouring lane stays equal. The bench provokes this by flipping each of the 32 bit positions, one at a time, under every one of the eight enable settings. It also runs random operand pairs with equality forced on chosen segments. Each result is judged against an independent model. The model walks segments upward from each lane start until it reaches an open cut, so a flag that leaks across a closed boundary, or a mismatch hidden by a merge, shows up as a miscompare.

// File: rtl/part_eq_pkg.sv
package part_eq_pkg;
  localparam int DEF_WIDTH = 32;
  localparam int DEF_SEGS  = 4;
  localparam int DEF_SEG_W = 4;
endpackage

// File: rtl/part_eq_seg.sv
module part_eq_seg #(
  parameter int WIDTH = 32,
  parameter int SEGS  = 4,
  parameter int SEG_W = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [SEGS-1:0]  seg_match
);
  // Every segment except the last is SEG_W wide; the last takes the rest.
  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    localparam int LO = s * SEG_W;
    localparam int HI = (s == SEGS - 1) ? WIDTH - 1 : LO + SEG_W - 1;
    assign seg_match[s] = (a[HI:LO] == b[HI:LO]);
  end
endmodule

// File: rtl/part_eq_chain.sv
module part_eq_chain #(
  parameter int SEGS = 4
) (
  input  logic [SEGS-1:0] seg_match,
  input  logic [SEGS-2:0] cuts,
  output logic [SEGS-1:0] lane_eq
);
  // run[j]: segments j upward, up to the next open cut, all match.
  logic [SEGS-1:0] run;
  logic [SEGS-1:0] head;

  assign run[SEGS-1]  = seg_match[SEGS-1];
  assign head[0]      = 1'b1;
  assign head[SEGS-1:1] = cuts;

  for (genvar j = SEGS - 2; j >= 0; j--) begin : g_run
    assign run[j] = seg_match[j] & (cuts[j] | run[j+1]);
  end

  assign lane_eq = run & head;
endmodule

// File: rtl/part_eq.sv
module part_eq
  import part_eq_pkg::*;
#(
  parameter int WIDTH = DEF_WIDTH,
  parameter int SEGS  = DEF_SEGS,
  parameter int SEG_W = DEF_SEG_W
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [SEGS-2:0]  cut_en,
  output logic [SEGS-1:0]  lane_eq
);
  localparam int TOP_LO = (SEGS - 1) * SEG_W;

  logic [SEGS-1:0] seg_match;

  part_eq_seg #(.WIDTH(WIDTH), .SEGS(SEGS), .SEG_W(SEG_W)) u_seg (
    .a(opa),
    .b(opb),
    .seg_match(seg_match)
  );

  part_eq_chain #(.SEGS(SEGS)) u_chain (
    .seg_match(seg_match),
    .cuts(cut_en),
    .lane_eq(lane_eq)
  );

  always_comb begin
    if (!$isunknown({opa, opb, cut_en})) begin
      assert_nonhead_zero_R5: assert ((lane_eq & ~{cut_en, 1'b1}) == '0)
        else $error("non-start flag set");
      if (opa == opb) begin
        assert_equal_heads_R4: assert (lane_eq == {cut_en, 1'b1})
          else $error("equal operands: wrong lane-start pattern");
      end
      if (cut_en == '0) begin
        assert_single_lane_R6: assert (lane_eq == {{(SEGS-1){1'b0}}, (opa == opb)})
          else $error("single lane mismatch");
      end
      if (lane_eq[SEGS-1]) begin
        assert_top_seg_R1: assert (opa[WIDTH-1:TOP_LO] == opb[WIDTH-1:TOP_LO])
          else $error("top lane flag with unequal top segment");
      end
      if (lane_eq[0]) begin
        assert_low_seg_R3: assert (opa[SEG_W-1:0] == opb[SEG_W-1:0])
          else $error("low lane flag with unequal low segment");
      end
    end
  end
endmodule

// File: tb/part_eq_bench.sv
`timescale 1ns/1ps
module part_eq_bench;
  logic        clk = 1'b0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [2:0]  cut_en = '0;
  logic [3:0]  lane_eq;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  part_eq u_part_eq (
    .opa(opa), .opb(opb), .cut_en(cut_en), .lane_eq(lane_eq)
  );

  function automatic int seg_of(int k);
    return (k < 12) ? k / 4 : 3;
  endfunction

  function automatic bit seg_same(logic [31:0] a, logic [31:0] b, int s);
    bit r = 1;
    for (int k = 0; k < 32; k++)
      if (seg_of(k) == s && a[k] != b[k]) r = 0;
    return r;
  endfunction

  function automatic logic [3:0] model(logic [31:0] a, logic [31:0] b, logic [2:0] g);
    logic [3:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      if (i == 0 || g[i-1]) begin
        bit ok = 1;
        int j = i;
        bit stop = 0;
        while (!stop) begin
          if (!seg_same(a, b, j)) ok = 0;
          if (j == 3 || g[j]) stop = 1;
          else j++;
        end
        r[i] = ok;
      end
    end
    return r;
  endfunction

  task automatic apply(logic [31:0] a, logic [31:0] b, logic [2:0] g, string tag);
    logic [3:0] exp;
    @(negedge clk);
    opa = a; opb = b; cut_en = g;
    #5;
    exp = model(a, b, g);
    n_vec++;
    if (lane_eq !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h cut=%b got=%b exp=%b", tag, a, b, g, lane_eq, exp);
    end
  endtask

  // R6: idle inputs give a single equal lane
  task automatic t_idle();
    apply(32'h0, 32'h0, 3'b000, "R6 idle");
    if (lane_eq !== 4'b0001) begin
      n_fail++;
      $display("FAIL R6 idle literal: got=%b exp=0001", lane_eq);
    end
  endtask

  // R4 R5: equal operands give the lane-start pattern
  task automatic t_all_equal();
    for (int g = 0; g < 8; g++) begin
      logic [31:0] v = $urandom;
      apply(v, v, g[2:0], "R4 equal");
      if (lane_eq !== {g[2:0], 1'b1}) begin
        n_fail++;
        $display("FAIL R4 head pattern: got=%b exp=%b", lane_eq, {g[2:0], 1'b1});
      end
    end
  endtask

  // R6: whole-word lane
  task automatic t_full_word();
    for (int n = 0; n < 20; n++) begin
      logic [31:0] v = $urandom;
      apply(v, v ^ (32'h1 << (n % 32)), 3'b000, "R6 full word diff");
      apply(v, v, 3'b000, "R6 full word eq");
    end
  endtask

  // R7: every segment separate
  task automatic t_split_all();
    for (int m = 0; m < 16; m++) begin
      logic [31:0] a = $urandom;
      logic [31:0] b = a;
      if (!m[0]) b[3:0]   = ~a[3:0];
      if (!m[1]) b[7:4]   = ~a[7:4];
      if (!m[2]) b[11:8]  = ~a[11:8];
      if (!m[3]) b[31:12] = ~a[31:12];
      apply(a, b, 3'b111, "R7 split");
      if (lane_eq !== m[3:0]) begin
        n_fail++;
        $display("FAIL R7 literal: got=%b exp=%b", lane_eq, m[3:0]);
      end
    end
  endtask

  // R9 R2: single bit flips across every setting
  task automatic t_single_flip();
    for (int g = 0; g < 8; g++)
      for (int k = 0; k < 32; k++) begin
        logic [31:0] a = $urandom;
        apply(a, a ^ (32'h1 << k), g[2:0], "R9 R2 single flip");
      end
  endtask

  // R1: bits on each side of every boundary
  task automatic t_boundary();
    int pos [8] = '{3, 4, 7, 8, 11, 12, 31, 0};
    for (int p = 0; p < 8; p++) begin
      logic [31:0] a = $urandom;
      apply(a, a ^ (32'h1 << pos[p]), 3'b111, "R1 boundary");
    end
  endtask

  // R3 R8: random pairs with equality forced on chosen segments
  task automatic t_random_forced();
    for (int g = 0; g < 8; g++)
      for (int n = 0; n < 40; n++) begin
        logic [31:0] a = $urandom;
        logic [31:0] b = $urandom;
        logic [3:0]  f = $urandom;
        if (f[0]) b[3:0]   = a[3:0];
        if (f[1]) b[7:4]   = a[7:4];
        if (f[2]) b[11:8]  = a[11:8];
        if (f[3]) b[31:12] = a[31:12];
        apply(a, b, g[2:0], "R3 R8 random");
      end
  endtask

  initial begin
    t_idle();
    t_all_equal();
    t_full_word();
    t_split_all();
    t_boundary();
    t_single_flip();
    t_random_forced();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got=timeout exp=completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule